// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared two-port memory array and watches the select and word-address inputs of its left and right ports. When both ports are selected and point at the same word, it decides which port keeps going and reports a busy condition to the other one only. The write strobe of the losing port is masked before it reaches the array, so a write that lost arbitration is silently dropped. The decision looks at select and address only; whether either access is a read or a write plays no part.

Arrival order decides the winner. Each clock the block registers a snapshot of both ports' requests. A port whose selected address is the same as in the previous cycle counts as already present, and a newcomer that collides with it loses. When both arrive together, or both were already present, the left port wins. The loss is kept until the winner deselects or moves to another address. Busy is released one cycle later.

A mode input picks between two roles. In master mode the block arbitrates and drives the active-low busy outputs. In slave mode it does not arbitrate. Its busy outputs stay inactive, and the separate active-low busy inputs act purely as write inhibits, one for each port. Several arrays wired in parallel can then follow one master's decision.

Top module: `dp_collision_arbiter`

## Requirements
- R1: Busy outputs are active low (0 = busy) and are always driven to 0 or 1. If in some cycle either port is deselected or the two word addresses differ, both busy outputs are 1 in the following cycle.
- R2: In master mode, when a port's request (selected, same address as in the previous cycle) was already present and the other port newly arrives at the same address, the newcomer's busy output goes to 0 in the next cycle and the earlier port's stays 1.
- R3: The two busy outputs are never 0 at the same time.
- R4: A collision in which both ports are reading (write strobes 0) produces busy exactly as a write collision does.
- R5: In master mode, the write strobe passed to the array for a port is forced to 0 in the cycle that port loses a collision and in every cycle its busy output is 0. The winning port's write strobe passes through unchanged.
- R6: In slave mode both busy outputs stay 1. Each port's write strobe passes through while its busy input is 1 and is forced to 0 while its busy input is 0. The busy inputs change nothing else.
- R7: In master mode the busy inputs have no effect on the write strobes or busy outputs.
- R8: In master mode, when both ports newly arrive at the same address in the same cycle, the right port loses.
- R9: Once busy is given, it holds while the collision lasts, even though both requests have become old. It returns to 1 one cycle after the winner deselects or changes address.
- R10: Busy appears at the output exactly one clock after the first cycle in which the colliding address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = arbitrate and drive busy, 0 = busy inputs inhibit writes |
| lSel | input | 1 | Left port select |
| lAddr | input | ADDR_W | Left port word address |
| lWe | input | 1 | Left port write strobe from the requester |
| rSel | input | 1 | Right port select |
| rAddr | input | ADDR_W | Right port word address |
| rWe | input | 1 | Right port write strobe from the requester |
| lBusyInN | input | 1 | Left busy input, active low, used in slave mode |
| rBusyInN | input | 1 | Right busy input, active low, used in slave mode |
| lBusyOutN | output | 1 | Left busy output, active low |
| rBusyOutN | output | 1 | Right busy output, active low |
| lWeGated | output | 1 | Left write strobe to the array |
| rWeGated | output | 1 | Right write strobe to the array |

## Verification
The bench looks at arrival order from both sides and at the simultaneous tie. A design that compared only the current cycle would flag the wrong port or always the same one. It also holds a collision across several cycles and then moves the winner away. This exposes a design that re-decided each cycle and passed busy to the other side once both requests had become old, or one that never released. Read-read collisions, plus the gating in the first collision cycle and during the hold, catch designs that qualify busy with the write strobe or let a losing write through. Slave mode and master mode are each driven with busy inputs low, which catches inputs that are ignored when they should not be, or obeyed when they should not be.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;

  typedef enum logic [1:0] {
    LOSER_NONE  = 2'd0,
    LOSER_LEFT  = 2'd1,
    LOSER_RIGHT = 2'd2
  } loser_e;

  // observations handed from datapath to control
  typedef struct packed {
    logic match;   // both selected, same word
    logic lOld;    // left request unchanged since last cycle
    logic rOld;    // right request unchanged since last cycle
  } view_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic lBusy;
    logic rBusy;
    logic lBlock;
    logic rBlock;
  } strobe_t;

endpackage

// File: rtl/dp_arb_datapath.sv
module dp_arb_datapath
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lSel,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWe,
  input  logic              rSel,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWe,
  input  strobe_t           strobes,
  output view_t             view,
  output logic              lBusyOutN,
  output logic              rBusyOutN,
  output logic              lWeGated,
  output logic              rWeGated
);

  localparam int PORTS = 2;

  logic [PORTS-1:0]             selNow;
  logic [PORTS-1:0][ADDR_W-1:0] addrNow;
  logic [PORTS-1:0]             selQ;
  logic [PORTS-1:0][ADDR_W-1:0] addrQ;
  logic [PORTS-1:0]             isOld;

  assign selNow  = {rSel, lSel};
  assign addrNow = {rAddr, lAddr};

  // per-port request snapshot and "already present" detection
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ[p]  <= 1'b0;
        addrQ[p] <= '0;
      end else begin
        selQ[p]  <= selNow[p];
        addrQ[p] <= addrNow[p];
      end
    end
    assign isOld[p] = selNow[p] && selQ[p] && (addrQ[p] == addrNow[p]);
  end

  always_comb begin
    view.match = lSel && rSel && (lAddr == rAddr);
    view.lOld  = isOld[0];
    view.rOld  = isOld[1];
  end

  assign lBusyOutN = ~strobes.lBusy;
  assign rBusyOutN = ~strobes.rBusy;
  assign lWeGated  = lWe && !strobes.lBlock;
  assign rWeGated  = rWe && !strobes.rBlock;

endmodule

// File: rtl/dp_arb_control.sv
module dp_arb_control
  import dp_arb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    masterMode,
  input  logic    lBusyInN,
  input  logic    rBusyInN,
  input  view_t   view,
  output strobe_t strobes
);

  loser_e loserQ, loserD;

  always_comb begin
    loserD = LOSER_NONE;
    if (masterMode && view.match) begin
      if (loserQ != LOSER_NONE)
        loserD = loserQ;                 // keep an existing decision
      else if (view.rOld && !view.lOld)
        loserD = LOSER_LEFT;             // right was first
      else
        loserD = LOSER_RIGHT;            // left first, or tie
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loserQ <= LOSER_NONE;
    else       loserQ <= loserD;
  end

  always_comb begin
    if (masterMode) begin
      strobes.lBusy  = (loserQ == LOSER_LEFT);
      strobes.rBusy  = (loserQ == LOSER_RIGHT);
      strobes.lBlock = (loserD == LOSER_LEFT)  || (loserQ == LOSER_LEFT);
      strobes.rBlock = (loserD == LOSER_RIGHT) || (loserQ == LOSER_RIGHT);
    end else begin
      strobes.lBusy  = 1'b0;
      strobes.rBusy  = 1'b0;
      strobes.lBlock = !lBusyInN;
      strobes.rBlock = !rBusyInN;
    end
  end

endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              lSel,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWe,
  input  logic              rSel,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWe,
  input  logic              lBusyInN,
  input  logic              rBusyInN,
  output logic              lBusyOutN,
  output logic              rBusyOutN,
  output logic              lWeGated,
  output logic              rWeGated
);

  view_t   view;
  strobe_t strobes;

  dp_arb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .lSel(lSel), .lAddr(lAddr), .lWe(lWe),
    .rSel(rSel), .rAddr(rAddr), .rWe(rWe),
    .strobes(strobes), .view(view),
    .lBusyOutN(lBusyOutN), .rBusyOutN(rBusyOutN),
    .lWeGated(lWeGated), .rWeGated(rWeGated)
  );

  dp_arb_control u_ctl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .lBusyInN(lBusyInN), .rBusyInN(rBusyInN),
    .view(view), .strobes(strobes)
  );

endmodule

// File: rtl/dp_collision_arbiter_chk.sv
module dp_collision_arbiter_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic              lSel,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lWe,
  input logic              rSel,
  input logic [ADDR_W-1:0] rAddr,
  input logic              rWe,
  input logic              lBusyInN,
  input logic              rBusyInN,
  input logic              lBusyOutN,
  input logic              rBusyOutN,
  input logic              lWeGated,
  input logic              rWeGated
);

  logic collide;
  assign collide = lSel && rSel && (lAddr == rAddr);

  // R1: no collision this cycle -> both busy released next cycle
  p_no_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    !collide |=> (lBusyOutN && rBusyOutN));

  // R3: never both busy
  p_mutex_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!lBusyOutN && !rBusyOutN));

  // R5: a busy port never writes
  p_gate_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    !lBusyOutN |-> !lWeGated);
  p_gate_right_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rBusyOutN |-> !rWeGated);

  // R6: slave mode follows the busy inputs only
  p_slave_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (lWeGated == (lWe && lBusyInN)) && (rWeGated == (rWe && rBusyInN)));
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> (lBusyOutN && rBusyOutN));

  // R8: simultaneous fresh collision gates the right write
  p_tie_r8: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && collide && lBusyOutN && rBusyOutN &&
     $past(!lSel && !rSel)) |-> (!rWeGated && (lWeGated == lWe)));

endmodule

bind dp_collision_arbiter dp_collision_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dp_collision_arbiter_test.sv
module dp_collision_arbiter_test;

  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic lSel = 1'b0, rSel = 1'b0, lWe = 1'b0, rWe = 1'b0;
  logic [ADDR_W-1:0] lAddr = '0, rAddr = '0;
  logic lBusyInN = 1'b1, rBusyInN = 1'b1;
  logic lBusyOutN, rBusyOutN, lWeGated, rWeGated;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dp_collision_arbiter #(.ADDR_W(ADDR_W)) uut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // advance to next negedge (one posedge passes)
  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    lSel = 0; rSel = 0; lWe = 0; rWe = 0;
    lBusyInN = 1; rBusyInN = 1; masterMode = 1;
    step(); step();
  endtask

  task automatic t_reset();
    chk("R1 reset lBusy", lBusyOutN, 1'b1);
    chk("R1 reset rBusy", rBusyOutN, 1'b1);
  endtask

  task automatic t_left_first();
    lSel = 1; lAddr = 14'h0123; lWe = 1; step();
    rSel = 1; rAddr = 14'h0123; rWe = 1; #2;
    chk("R5 right gated first cycle", rWeGated, 1'b0);
    chk("R5 left passes", lWeGated, 1'b1);
    step();
    chk("R2 R10 right busy", rBusyOutN, 1'b0);
    chk("R2 left not busy", lBusyOutN, 1'b1);
    step(); step();
    chk("R9 hold right busy", rBusyOutN, 1'b0);
    chk("R5 right still gated", rWeGated, 1'b0);
    lAddr = 14'h0124; #2;
    chk("R5 gated in release cycle", rWeGated, 1'b0);
    step();
    chk("R9 released after move", rBusyOutN, 1'b1);
    chk("R1 left stays free", lBusyOutN, 1'b1);
    idle();
  endtask

  task automatic t_right_first();
    rSel = 1; rAddr = 14'h3FFE; rWe = 1; step();
    lSel = 1; lAddr = 14'h3FFE; lWe = 1; #2;
    chk("R5 left gated", lWeGated, 1'b0);
    chk("R5 right passes", rWeGated, 1'b1);
    step();
    chk("R2 left busy", lBusyOutN, 1'b0);
    chk("R2 right free", rBusyOutN, 1'b1);
    rSel = 0; step();
    chk("R9 release on deselect", lBusyOutN, 1'b1);
    idle();
  endtask

  task automatic t_tie_read();
    lSel = 1; rSel = 1; lAddr = 14'h0055; rAddr = 14'h0055; step();
    chk("R8 R4 right busy on tie", rBusyOutN, 1'b0);
    chk("R8 left free on tie", lBusyOutN, 1'b1);
    idle();
  endtask

  task automatic t_mismatch();
    lSel = 1; rSel = 1; lAddr = 14'h0010; rAddr = 14'h0011; lWe = 1; rWe = 1; #2;
    chk("R1 mismatch left write", lWeGated, 1'b1);
    chk("R1 mismatch right write", rWeGated, 1'b1);
    step();
    chk("R1 mismatch lBusy", lBusyOutN, 1'b1);
    chk("R1 mismatch rBusy", rBusyOutN, 1'b1);
    lSel = 0; rAddr = 14'h0010; step();
    chk("R1 deselected rBusy", rBusyOutN, 1'b1);
    idle();
  endtask

  task automatic t_master_ignores_inputs();
    lBusyInN = 0; rBusyInN = 0; lSel = 1; lWe = 1; lAddr = 14'h0001; #2;
    chk("R7 left write ignores input", lWeGated, 1'b1);
    step();
    chk("R7 busy out unaffected", lBusyOutN, 1'b1);
    idle();
  endtask

  task automatic t_slave();
    masterMode = 0; step();
    lSel = 1; rSel = 1; lAddr = 14'h0200; rAddr = 14'h0200; lWe = 1; rWe = 1;
    lBusyInN = 0; #2;
    chk("R6 left inhibited", lWeGated, 1'b0);
    chk("R6 right passes", rWeGated, 1'b1);
    step();
    chk("R6 slave lBusy high", lBusyOutN, 1'b1);
    chk("R6 slave rBusy high", rBusyOutN, 1'b1);
    lBusyInN = 1; rBusyInN = 0; #2;
    chk("R6 left released", lWeGated, 1'b1);
    chk("R6 right inhibited", rWeGated, 1'b0);
    idle();
  endtask

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    t_reset();
    t_left_first();
    t_right_first();
    t_tie_read();
    t_mismatch();
    t_master_ignores_inputs();
    t_slave();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule